// File: doc/BRIEF.md
# Window Coefficient Sequencing Controller

This block sets the order in which a tapered spectral window (Kaiser type) is computed on one shared special-function kernel. The kernel sits outside the block. It is reached through a request port and answers after a fixed number of cycles. A one-cycle load pulse takes in a window length code and a shape value. The controller then makes one pass with the shape value as the kernel argument. It latches the returned normalising value and holds it.

After that pass the controller switches the kernel to the per-sample path. It issues one argument per clock from an arithmetic ramp. Each returned value goes to an external divider together with the held normalising value. The quotient is the window coefficient. The controller multiplies the coefficient with the sample that arrives in the same cycle, which gives one windowed sample per clock.

The window length is always a power of two, `N = 2^E`, with E from 3 to 15. The shape value is unsigned, with 4 integer bits and 12 fraction bits, so it reaches just under 16.0. A new load restarts the whole sequence from any state.

Top module: `wincoef_seq`

## Requirements
- R1: After reset, and until the first load, `kreq_valid`, `smp_take` and `win_valid` stay low and `win_data` is zero.
- R2: A load in cycle L captures `len_code` and `beta`. In cycle L+1 exactly one request is issued, with `kreq_den`=1 and `kreq_arg` equal to `beta` zero-extended.
- R3: The kernel response present in cycle L+1+KLAT is latched and driven on `div_den`. It stays unchanged through the whole per-sample phase. Responses in any other cycle do not alter it.
- R4: Per-sample requests run from cycle L+KLAT+2, one per clock, with `kreq_den`=0. There are exactly N = 2^E of them, with no gap.
- R5: Per-sample request n (0-based) carries the argument `-beta + n*(beta >> (E-1))` as an 18-bit two's complement value.
- R6: The effective exponent E equals `len_code` for codes 3..15. Codes 0..2 are treated as 3.
- R7: `smp_take` is high exactly KLAT cycles after each per-sample request. In that cycle, `div_quot` (unsigned, 15 fraction bits) for the response on `div_num` is multiplied with `sample_in`. In the next cycle `win_data` = floor(sample*quot/2^15), saturated to 16-bit signed.
- R8: A load in any state aborts the running sequence. From the next cycle on, no `smp_take` and no `win_valid` of the earlier sequence appear, and the new sequence follows the load timing above.
- R9: After the N-th per-sample request, no request is issued until the next load.
- R10: `win_valid` is high for N consecutive cycles, from L+2*KLAT+3 to L+2*KLAT+2+N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | One-cycle pulse: capture parameters and restart |
| len_code | input | 4 | Window length exponent E (N = 2^E) |
| beta | input | 16 | Shape value, unsigned, 12 fraction bits |
| sample_in | input | 16 | Signed input sample, used when `smp_take` is high |
| kreq_valid | output | 1 | Kernel request this cycle |
| kreq_den | output | 1 | Path select: 1 = normalising pass, 0 = per-sample path |
| kreq_arg | output | 18 | Signed kernel argument |
| kresp_data | input | 32 | Kernel result, valid KLAT cycles after its request |
| div_num | output | 32 | Divider dividend (kernel result) |
| div_den | output | 32 | Divider divisor (held normalising value) |
| div_quot | input | 16 | Divider quotient, unsigned, 15 fraction bits |
| smp_take | output | 1 | Sample consumed this cycle |
| win_valid | output | 1 | Windowed sample valid |
| win_data | output | 16 | Windowed sample, signed |

## Verification
The assertions check on every cycle these rules:
- the normalising request is a single cycle on the lower path;
- the held divisor changes only on its capture strobe;
- the per-sample stream starts right after the capture and never exceeds N requests;
- every valid output comes from a sample take;
- a load flushes the result pipeline.

Other properties need the reference model, which compares every cycle across scenarios: the latency alignment to the kernel, the exact ramp of arguments, the clamping of short length codes, the product arithmetic, and an abort both in mid-stream and during the normalising wait. The model also feeds junk kernel data in idle cycles, which shows that responses outside their slot are ignored.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEN_ISSUE,
    ST_DEN_WAIT,
    ST_STREAM,
    ST_DONE
  } wsq_state_e;

  localparam int unsigned WSQ_MIN_LOG = 3;
  localparam int unsigned WSQ_MAX_LOG = 15;

endpackage

// File: rtl/wsq_fsm.sv
module wsq_fsm
  import wsq_pkg::*;
#(
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned KLAT    = 4,
  parameter int unsigned MIN_LOG = WSQ_MIN_LOG,
  parameter int unsigned MAX_LOG = WSQ_MAX_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_code,
  output logic [LEN_W-1:0] len_new,
  output logic [LEN_W-1:0] len_eff,
  output logic             den_issue,
  output logic             den_capture,
  output logic             num_issue
);

  localparam int unsigned IDX_W = MAX_LOG;
  localparam int unsigned CNT_W = MAX_LOG + 1;
  localparam int unsigned WW    = $clog2(KLAT + 1);

  // Fold a length code into the supported exponent range
  function automatic logic [LEN_W-1:0] clamp_log(input logic [LEN_W-1:0] code);
    int unsigned v;
    v = code;
    if (v < MIN_LOG) v = MIN_LOG;
    if (v > MAX_LOG) v = MAX_LOG;
    return LEN_W'(v);
  endfunction

  wsq_state_e       state, nxt;
  logic [WW-1:0]    wcnt;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] n_total;
  logic [IDX_W-1:0] last_idx;
  logic             wait_done;

  assign len_new   = clamp_log(len_code);
  assign n_total   = CNT_W'(1) << len_eff;
  assign last_idx  = IDX_W'(n_total - CNT_W'(1));

  assign den_issue   = (state == ST_DEN_ISSUE);
  assign wait_done   = (state == ST_DEN_WAIT) && (wcnt == WW'(KLAT));
  assign den_capture = wait_done;
  assign num_issue   = (state == ST_STREAM);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      nxt = ST_IDLE;
      ST_DEN_ISSUE: nxt = ST_DEN_WAIT;
      ST_DEN_WAIT:  if (wait_done) nxt = ST_STREAM;
      ST_STREAM:    if (idx == last_idx) nxt = ST_DONE;
      ST_DONE:      nxt = ST_DONE;
      default:      nxt = ST_IDLE;
    endcase
    if (load) nxt = ST_DEN_ISSUE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      idx     <= '0;
      len_eff <= LEN_W'(MIN_LOG);
    end else begin
      state <= nxt;
      if (load) begin
        len_eff <= len_new;
        idx     <= '0;
        wcnt    <= '0;
      end else begin
        if (den_issue)                   wcnt <= WW'(1);
        else if (state == ST_DEN_WAIT)   wcnt <= wcnt + WW'(1);
        if (num_issue)                   idx  <= idx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/wsq_arggen.sv
module wsq_arggen #(
  parameter int unsigned BETA_W = 16,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned ARG_W  = BETA_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [BETA_W-1:0]       beta_in,
  input  logic [LEN_W-1:0]        len_new,
  input  logic                    num_issue,
  output logic signed [ARG_W-1:0] den_arg,
  output logic signed [ARG_W-1:0] num_arg
);

  // Ramp increment: beta divided by half the window length
  function automatic logic signed [ARG_W-1:0] ramp_step(
    input logic [BETA_W-1:0] b, input logic [LEN_W-1:0] lg);
    logic [ARG_W-1:0] u;
    u = ARG_W'(b) >> (lg - LEN_W'(1));
    return $signed(u);
  endfunction

  function automatic logic signed [ARG_W-1:0] ramp_start(input logic [BETA_W-1:0] b);
    return -$signed(ARG_W'(b));
  endfunction

  logic [BETA_W-1:0]       beta_q;
  logic signed [ARG_W-1:0] acc, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beta_q <= '0;
      acc    <= '0;
      step   <= '0;
    end else if (load) begin
      beta_q <= beta_in;
      acc    <= ramp_start(beta_in);
      step   <= ramp_step(beta_in, len_new);
    end else if (num_issue) begin
      acc <= acc + step;
    end
  end

  assign den_arg = $signed(ARG_W'(beta_q));
  assign num_arg = acc;

endmodule

// File: rtl/wsq_outstage.sv
module wsq_outstage #(
  parameter int unsigned KLAT      = 4,
  parameter int unsigned SMP_W     = 16,
  parameter int unsigned COEF_W    = 16,
  parameter int unsigned COEF_FRAC = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    num_issue,
  input  logic signed [SMP_W-1:0] sample_in,
  input  logic [COEF_W-1:0]       quot,
  output logic                    take,
  output logic                    win_valid,
  output logic signed [SMP_W-1:0] win_data
);

  localparam int unsigned PW = SMP_W + COEF_W + 1;
  localparam logic signed [PW-1:0] SMAX = PW'((2 ** (SMP_W - 1)) - 1);
  localparam logic signed [PW-1:0] SMIN = -PW'(2 ** (SMP_W - 1));

  // Sample times coefficient, floor-scaled and saturated
  function automatic logic signed [SMP_W-1:0] apply_coef(
    input logic signed [SMP_W-1:0] s, input logic [COEF_W-1:0] q);
    logic signed [PW-1:0] sx, qx, p, sh;
    sx = PW'(s);
    qx = $signed(PW'(q));
    p  = sx * qx;
    sh = p >>> COEF_FRAC;
    if (sh > SMAX)      sh = SMAX;
    else if (sh < SMIN) sh = SMIN;
    return SMP_W'(sh);
  endfunction

  logic [KLAT-1:0] vpipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vpipe[0] <= 1'b0;
    else if (load)  vpipe[0] <= 1'b0;
    else            vpipe[0] <= num_issue;
  end

  for (genvar g = 1; g < KLAT; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vpipe[g] <= 1'b0;
      else if (load)  vpipe[g] <= 1'b0;
      else            vpipe[g] <= vpipe[g-1];
    end
  end

  assign take = vpipe[KLAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_data  <= '0;
    end else begin
      win_valid <= take && !load;
      if (take) win_data <= apply_coef(sample_in, quot);
    end
  end

endmodule

// File: rtl/wincoef_seq.sv
module wincoef_seq
  import wsq_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned BETA_W    = 16,
  parameter int unsigned SMP_W     = 16,
  parameter int unsigned KER_W     = 32,
  parameter int unsigned COEF_W    = 16,
  parameter int unsigned COEF_FRAC = 15,
  parameter int unsigned KLAT      = 4,
  parameter int unsigned MIN_LOG   = WSQ_MIN_LOG,
  parameter int unsigned MAX_LOG   = WSQ_MAX_LOG,
  localparam int unsigned ARG_W    = BETA_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LEN_W-1:0]        len_code,
  input  logic [BETA_W-1:0]       beta,
  input  logic signed [SMP_W-1:0] sample_in,
  output logic                    kreq_valid,
  output logic                    kreq_den,
  output logic signed [ARG_W-1:0] kreq_arg,
  input  logic [KER_W-1:0]        kresp_data,
  output logic [KER_W-1:0]        div_num,
  output logic [KER_W-1:0]        div_den,
  input  logic [COEF_W-1:0]       div_quot,
  output logic                    smp_take,
  output logic                    win_valid,
  output logic signed [SMP_W-1:0] win_data
);

  // Named internal events, also observed by the bound checker
  logic [LEN_W-1:0]        len_new, len_eff;
  logic                    den_issue, den_capture, num_issue;
  logic signed [ARG_W-1:0] den_arg, num_arg;
  logic [KER_W-1:0]        den_q;

  wsq_fsm #(
    .LEN_W(LEN_W), .KLAT(KLAT), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .load(load), .len_code(len_code),
    .len_new(len_new), .len_eff(len_eff),
    .den_issue(den_issue), .den_capture(den_capture), .num_issue(num_issue)
  );

  wsq_arggen #(
    .BETA_W(BETA_W), .LEN_W(LEN_W), .ARG_W(ARG_W)
  ) u_arg (
    .clk(clk), .rst_n(rst_n), .load(load), .beta_in(beta),
    .len_new(len_new), .num_issue(num_issue),
    .den_arg(den_arg), .num_arg(num_arg)
  );

  // Path steering toward the shared kernel
  assign kreq_valid = den_issue || num_issue;
  assign kreq_den   = den_issue;
  assign kreq_arg   = den_issue ? den_arg : num_arg;

  // Normalising value holder: written only in the capture slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           den_q <= '0;
    else if (den_capture) den_q <= kresp_data;
  end

  assign div_num = kresp_data;
  assign div_den = den_q;

  wsq_outstage #(
    .KLAT(KLAT), .SMP_W(SMP_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .num_issue(num_issue),
    .sample_in(sample_in), .quot(div_quot),
    .take(smp_take), .win_valid(win_valid), .win_data(win_data)
  );

endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned KER_W   = 32,
  parameter int unsigned MAX_LOG = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             kreq_valid,
  input logic             kreq_den,
  input logic             den_issue,
  input logic             den_capture,
  input logic             num_issue,
  input logic [LEN_W-1:0] len_eff,
  input logic             smp_take,
  input logic             win_valid,
  input logic [KER_W-1:0] div_den
);

  localparam int unsigned NW = MAX_LOG + 2;

  logic          seen_load;
  logic [NW-1:0] issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_load <= 1'b0;
      issued    <= '0;
    end else begin
      if (load) seen_load <= 1'b1;
      if (load)           issued <= '0;
      else if (num_issue) issued <= issued + NW'(1);
    end
  end

  a_r1_quiet_before_load: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load |-> (!kreq_valid && !smp_take && !win_valid));

  a_r2_den_single: assert property (@(posedge clk) disable iff (!rst_n)
    den_issue |=> !den_issue);

  a_r2_den_path: assert property (@(posedge clk) disable iff (!rst_n)
    den_issue |-> (kreq_valid && kreq_den));

  a_r3_den_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !den_capture |=> $stable(div_den));

  a_r4_stream_start: assert property (@(posedge clk) disable iff (!rst_n)
    (den_capture && !load) |=> num_issue);

  a_r4_num_path: assert property (@(posedge clk) disable iff (!rst_n)
    num_issue |-> (kreq_valid && !kreq_den));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    num_issue |-> (issued < (NW'(1) << len_eff)));

  a_r7_take_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_take && !load) |=> win_valid);

  a_r7_out_from_take: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(smp_take));

  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!win_valid && !smp_take));

endmodule

bind wincoef_seq wsq_checker #(
  .LEN_W(LEN_W), .KER_W(KER_W), .MAX_LOG(MAX_LOG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load),
  .kreq_valid(kreq_valid), .kreq_den(kreq_den),
  .den_issue(den_issue), .den_capture(den_capture), .num_issue(num_issue),
  .len_eff(len_eff), .smp_take(smp_take), .win_valid(win_valid),
  .div_den(div_den)
);

// File: tb/wincoef_seq_test.sv
module wincoef_seq_test;

  localparam int K     = 4;
  localparam int NLOAD = 7;
  localparam int LAST  = 33100;

  logic               clk = 1'b0;
  logic               rst_n, load;
  logic [3:0]         len_code;
  logic [15:0]        beta;
  logic signed [15:0] sample_in;
  logic               kreq_valid, kreq_den;
  logic signed [17:0] kreq_arg;
  logic [31:0]        kresp_data, div_num, div_den;
  logic [15:0]        div_quot;
  logic               smp_take, win_valid;
  logic signed [15:0] win_data;

  always #2 clk = ~clk;

  wincoef_seq #(.KLAT(K)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .len_code(len_code), .beta(beta),
    .sample_in(sample_in), .kreq_valid(kreq_valid), .kreq_den(kreq_den),
    .kreq_arg(kreq_arg), .kresp_data(kresp_data), .div_num(div_num),
    .div_den(div_den), .div_quot(div_quot), .smp_take(smp_take),
    .win_valid(win_valid), .win_data(win_data)
  );

  // Load schedule: cycle, length code, shape value
  int ld_cyc [NLOAD] = '{10, 40, 70, 110, 113, 160, 33000};
  int ld_len [NLOAD] = '{3, 0, 6, 5, 4, 15, 2};
  int ld_beta[NLOAD] = '{20480, 0, 61440, 1000, 65535, 34816, 4096};

  int  checks = 0, fails = 0;
  bit  done = 0;
  bit  rq_v[16];
  longint rq_a[16];

  // Behavioural kernel: any positive function of the argument
  function automatic longint kern(longint a);
    longint m;
    m = (a < 0) ? -a : a;
    m = m >>> 2;
    return 64'd16777216 + m * m;
  endfunction

  function automatic longint quot(longint n, longint d);
    longint q;
    if (d == 0) return 65535;
    q = (n * 32768) / d;
    return (q > 65535) ? 65535 : q;
  endfunction

  function automatic longint wmul(longint s, longint q);
    longint p;
    p = (s * q) >>> 15;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  function automatic int samp(int c);
    return ((c * 7919 + 12345) % 65536) - 32768;
  endfunction

  function automatic int eff_log(int code);
    return (code < 3) ? 3 : code;
  endfunction

  assign div_quot = 16'(quot(longint'(div_num), longint'(div_den)));

  task automatic cmp(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle-check: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_cycle(int c);
    int k, r, e, n, nn;
    longint b, step, ekv, ekd, earg, etake, ewv, edata;
    k = -1;
    for (int i = 0; i < NLOAD; i++) if (ld_cyc[i] < c) k = i;
    if (k < 0) begin
      cmp("R1 kreq_valid", kreq_valid, 0);
      cmp("R1 smp_take", smp_take, 0);
      cmp("R1 win_valid", win_valid, 0);
      cmp("R1 win_data", win_data, 0);
      return;
    end
    r    = c - ld_cyc[k];
    e    = eff_log(ld_len[k]);
    nn   = 1 << e;
    b    = ld_beta[k];
    step = b >>> (e - 1);
    ekv  = (r == 1 || (r >= K + 2 && r <= K + 1 + nn)) ? 1 : 0;
    etake = (r >= 2*K + 2 && r <= 2*K + 1 + nn) ? 1 : 0;
    ewv  = (r >= 2*K + 3 && r <= 2*K + 2 + nn) ? 1 : 0;
    if (r == 1) begin
      cmp("R2 kreq_valid", kreq_valid, 1);
      cmp("R2 kreq_den", kreq_den, 1);
      cmp("R2 kreq_arg", kreq_arg, b);
    end else if (ekv == 1) begin
      n = r - K - 2;
      cmp("R4 R6 kreq_valid", kreq_valid, 1);
      cmp("R4 kreq_den", kreq_den, 0);
      cmp("R5 kreq_arg", kreq_arg, -b + n * step);
    end else begin
      cmp((r > K + 1) ? "R9 kreq_valid" : "R4 kreq_valid", kreq_valid, 0);
    end
    if (r >= K + 2) cmp("R3 div_den", div_den, kern(b));
    cmp((r <= 2) ? "R8 smp_take" : "R7 smp_take", smp_take, etake);
    cmp((r <= 2) ? "R8 win_valid" : "R10 win_valid", win_valid, ewv);
    if (ewv == 1 && win_valid) begin
      n = r - 2*K - 3;
      earg  = -b + n * step;
      edata = wmul(samp(c - 1), quot(kern(earg), kern(b)));
      cmp("R7 win_data", win_data, edata);
    end
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; len_code = '0; beta = '0;
    sample_in = 16'(samp(0)); kresp_data = 32'hA5A50000;
    for (int i = 0; i < 16; i++) begin rq_v[i] = 0; rq_a[i] = 0; end
    for (int c = 1; c <= LAST; c++) begin
      @(negedge clk);
      if (c >= 3) rst_n = 1'b1;
      if (c >= 4) check_cycle(c);
      rq_v[c % 16] = kreq_valid;
      rq_a[c % 16] = longint'(kreq_arg);
      // Drive this cycle's inputs, sampled at the edge ending it
      load = 1'b0;
      for (int i = 0; i < NLOAD; i++) begin
        if (ld_cyc[i] == c) begin
          load = 1'b1; len_code = 4'(ld_len[i]); beta = 16'(ld_beta[i]);
        end
      end
      sample_in = 16'(samp(c));
      if (c - K >= 1 && rq_v[(c - K) % 16])
        kresp_data = 32'(kern(rq_a[(c - K) % 16]));
      else
        kresp_data = 32'hA5A50000 ^ 32'(c);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule